// File: doc/BRIEF.md
# Staged Radix-4 Lane Rotator

This block takes a wide vector of 256 lanes of 7 bits and produces a 128-lane window of it, rotated cyclically by a 7-bit amount from 0 to 127. It is the permutation step of a decoder for a quasi-cyclic lifted code whose lift size is not a power of two. Every block of such a code is a rotated identity, so one rotator serves every edge of the code.

The rotation is split into four cascaded stages. Each stage moves the vector by a power-of-four multiple, and the step is chosen by a balanced multiplexer that is driven straight from two raw bits of the shift amount. A register cut after the second stage splits the path. The upper shift bits travel through that cut alongside the data. One module serves both directions. With `REVERSE` set, the block negates the shift amount modulo 128 and adds a second register at the output. Beats enter and leave through valid/ready handshakes. A beat transfers on a clock edge where valid and ready are both high. While the downstream side holds ready low, the output beat stays frozen, and the stall passes back stage by stage.

Top module: `lane_rotator`

## Requirements
- R1: With REVERSE=0 and shift amount s, output lane i (bits 7i+6..7i of `out_lanes`) equals input lane (i+s) mod 256 (bits 7j+6..7j of `in_lanes`) of the same beat.
- R2: With REVERSE=1 the effective shift is (128 - s) mod 128, and output lane i equals input lane (i + that amount) mod 256.
- R3: Every shift amount from 0 to 127 gives the mapping of R1 or R2. The amount is made of offsets 0..3, 0/4/8/12, 0/16/32/48 and 0/64, taken from shift bits [1:0], [3:2], [5:4] and [6].
- R4: With REVERSE=0, a beat accepted at a clock edge is presented with `out_valid` high right after that edge.
- R5: With REVERSE=1, a beat accepted at a clock edge is presented one edge later than under R4.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_lanes` stays unchanged on the next cycle.
- R7: `in_ready` is high in every cycle in which `out_ready` is high or `out_valid` is low.
- R8: Directly after reset, `out_valid` is low and `in_ready` is high.
- R9: Under any pattern of back-pressure, beats leave in the order they were accepted, with none lost and none duplicated.
- R10: Back-to-back beats with different shift amounts are each rotated by their own amount. The shift bits used after the register cut stay aligned with their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The rotator accepts the offered beat |
| in_shift | input | 7 | Rotation amount of the beat |
| in_lanes | input | 1792 | 256 input lanes, 7 bits each, lane 0 in the low bits |
| out_valid | output | 1 | A rotated beat is presented |
| out_ready | input | 1 | Downstream takes the presented beat |
| out_lanes | output | 896 | 128 rotated lanes, lane 0 in the low bits |

## Verification
A wrong select bit or a misplaced stage offset shows up at the output as a whole-window displacement by a power-of-four multiple. It appears on the first beat whose shift amount sets that bit, one clock (forward) or two clocks (reverse) after acceptance. A shift register that is out of step with the data only shows when consecutive beats carry different amounts, so beats are streamed back to back. A handshake fault, such as a lost stall or a register that is overwritten while full, shows up as a beat that is missing, repeated or changed while `out_ready` is low, within a few cycles of the stall. Each of these is exposed by sweeping every amount in both directions, with and without random back-pressure.

// File: rtl/lane_rot_pkg.sv
`timescale 1ns/1ps
package lane_rot_pkg;

  // number of radix-4 stages needed to cover a shift field
  function automatic int unsigned lrot_stage_count(int unsigned shift_w);
    return (shift_w + 1) / 2;
  endfunction

  // select bits consumed by one stage (last stage may take one bit)
  function automatic int unsigned lrot_sel_width(int unsigned shift_w, int unsigned stage);
    int unsigned rem;
    rem = shift_w - 2 * stage;
    return (rem >= 2) ? 2 : rem;
  endfunction

  // lane distance of one select increment in a stage
  function automatic int unsigned lrot_step(int unsigned stage);
    return 1 << (2 * stage);
  endfunction

endpackage

// File: rtl/lane_rot_stage.sv
`timescale 1ns/1ps
// One rotation stage: every output lane picks among 2**SEL_W input lanes
// spaced STEP apart, indexed directly by the raw select bits.
module lane_rot_stage #(
  parameter int unsigned LANES = 256,
  parameter int unsigned W     = 7,
  parameter int unsigned STEP  = 1,
  parameter int unsigned SEL_W = 2
) (
  input  logic [LANES*W-1:0] d,
  input  logic [SEL_W-1:0]   sel,
  output logic [LANES*W-1:0] q
);
  localparam int unsigned NCH = 1 << SEL_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [W-1:0] cand [NCH];
    for (genvar m = 0; m < NCH; m++) begin : g_cand
      localparam int unsigned SRC = (j + m * STEP) % LANES;
      assign cand[m] = d[SRC*W +: W];
    end
    assign q[j*W +: W] = cand[sel];
  end
endmodule

// File: rtl/lane_rot_slice.sv
`timescale 1ns/1ps
// Single-entry valid/ready register; accepts whenever empty or draining.
module lane_rot_slice #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) begin
      dn_data <= up_data;
    end
  end
endmodule

// File: rtl/lane_rotator.sv
`timescale 1ns/1ps
module lane_rotator
  import lane_rot_pkg::*;
#(
  parameter int unsigned IN_LANES  = 256,
  parameter int unsigned OUT_LANES = 128,
  parameter int unsigned LANE_W    = 7,
  parameter int unsigned SHIFT_W   = 7,
  parameter int unsigned CUT_AFTER = 1,
  parameter bit          REVERSE   = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SHIFT_W-1:0]          in_shift,
  input  logic [IN_LANES*LANE_W-1:0]  in_lanes,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [OUT_LANES*LANE_W-1:0] out_lanes
);
  localparam int unsigned NST   = lrot_stage_count(SHIFT_W);
  localparam int unsigned VW    = IN_LANES * LANE_W;
  localparam int unsigned OW    = OUT_LANES * LANE_W;
  localparam int unsigned HI_LO = 2 * (CUT_AFTER + 1);
  localparam int unsigned HI_W  = SHIFT_W - HI_LO;

  // reverse direction applies the two's-complement amount
  logic [SHIFT_W-1:0] shift_eff;
  assign shift_eff = REVERSE ? (SHIFT_W'(0) - in_shift) : in_shift;

  logic [VW-1:0]      st_in  [NST];
  logic [VW-1:0]      st_out [NST];
  logic [HI_W+VW-1:0] cut_q;
  logic [HI_W-1:0]    cut_hi;
  logic [VW-1:0]      cut_data;
  logic               cut_valid;
  logic               cut_ready;

  assign st_in[0] = in_lanes;
  assign cut_hi   = cut_q[HI_W+VW-1:VW];
  assign cut_data = cut_q[VW-1:0];

  for (genvar k = 0; k < NST; k++) begin : g_stage
    localparam int unsigned SW = lrot_sel_width(SHIFT_W, k);
    logic [SW-1:0] sel;
    if (k <= CUT_AFTER) begin : g_early
      assign sel = shift_eff[2*k +: SW];
    end else begin : g_late
      assign sel = cut_hi[2*k-HI_LO +: SW];
    end
    if (k > 0) begin : g_link
      if (k == CUT_AFTER + 1) begin : g_from_cut
        assign st_in[k] = cut_data;
      end else begin : g_from_prev
        assign st_in[k] = st_out[k-1];
      end
    end
    lane_rot_stage #(
      .LANES(IN_LANES), .W(LANE_W), .STEP(lrot_step(k)), .SEL_W(SW)
    ) u_stage (
      .d(st_in[k]), .sel(sel), .q(st_out[k])
    );
  end

  // mid-cascade register: data after the early stages plus the late shift bits
  lane_rot_slice #(.DW(HI_W + VW)) u_cut (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({shift_eff[SHIFT_W-1:HI_LO], st_out[CUT_AFTER]}),
    .dn_valid (cut_valid),
    .dn_ready (cut_ready),
    .dn_data  (cut_q)
  );

  logic [OW-1:0] rot_win;
  assign rot_win = st_out[NST-1][OW-1:0];

  if (REVERSE) begin : g_rev_out
    lane_rot_slice #(.DW(OW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (cut_valid),
      .up_ready (cut_ready),
      .up_data  (rot_win),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (out_lanes)
    );
  end else begin : g_fwd_out
    assign out_valid = cut_valid;
    assign cut_ready = out_ready;
    assign out_lanes = rot_win;
  end
endmodule

// File: rtl/lane_rotator_chk.sv
`timescale 1ns/1ps
module lane_rotator_chk #(
  parameter int unsigned LAT = 1,
  parameter int unsigned OW  = 896
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_lanes
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes)));

  // R7
  in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready || !out_valid) |-> in_ready);

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  if (LAT == 1) begin : g_lat1
    // R4
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
  end else begin : g_lat2
    // R5
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 2));
  end
endmodule

bind lane_rotator lane_rotator_chk #(
  .LAT (REVERSE ? 2 : 1),
  .OW  (OUT_LANES * LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_lanes (out_lanes)
);

// File: tb/lane_rotator_tb_top.sv
`timescale 1ns/1ps
module lane_rotator_tb_lane #(
  parameter bit REV = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_err,
  output logic done
);
  logic         in_valid, in_ready, out_valid, out_ready, bp_en;
  logic [6:0]   in_shift;
  logic [1791:0] in_lanes;
  logic [895:0] out_lanes, prev_lanes;
  logic         prev_stall;
  logic [15:0]  lfsr;
  int tx_shift [300];
  int tx_seed  [300];
  int tx_cnt, rx_cnt;
  int m_chk, m_err, d_chk, d_err;

  assign n_chk = m_chk + d_chk;
  assign n_err = m_err + d_err;

  lane_rotator #(.REVERSE(REV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_shift(in_shift), .in_lanes(in_lanes),
    .out_valid(out_valid), .out_ready(out_ready), .out_lanes(out_lanes)
  );

  // lanes j and j+128 always differ, so a mod-128 mistake is visible
  function automatic logic [6:0] lane_val(int seed, int lane);
    return 7'((lane * 5 + seed * 11 + (lane / 128) * 37) % 128);
  endfunction

  function automatic logic [1791:0] build(int seed);
    logic [1791:0] v;
    for (int j = 0; j < 256; j++) v[j*7 +: 7] = lane_val(seed, j);
    return v;
  endfunction

  task automatic send(int s, int seed);
    logic acc;
    tx_shift[tx_cnt] = s;
    tx_seed[tx_cnt]  = seed;
    tx_cnt++;
    in_shift = 7'(s);
    in_lanes = build(seed);
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic dchk(bit ok, string req, int act, int exp);
    d_chk++;
    if (!ok) begin
      d_err++;
      $display("FAIL %s rev=%0d actual %0d expected %0d", req, REV, act, exp);
    end
  endtask

  // back-pressure source
  initial begin
    out_ready = 1'b1;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor: data (R1, R2, R3, R10), hold (R6), ready rule (R7), order (R9)
  initial begin
    rx_cnt = 0; m_chk = 0; m_err = 0; prev_stall = 1'b0; prev_lanes = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          m_chk++;
          if (!out_valid || out_lanes != prev_lanes) begin
            m_err++;
            $display("FAIL R6 rev=%0d held beat changed: actual valid %0d expected 1", REV, out_valid);
          end
        end
        if (out_ready || !out_valid) begin
          m_chk++;
          if (!in_ready) begin
            m_err++;
            $display("FAIL R7 rev=%0d in_ready actual 0 expected 1", REV);
          end
        end
        if (out_valid && out_ready) begin
          m_chk++;
          if (rx_cnt >= tx_cnt) begin
            m_err++;
            $display("FAIL R9 rev=%0d extra beat actual %0d expected below %0d", REV, rx_cnt + 1, tx_cnt + 1);
          end else begin
            int eff;
            int bad;
            logic [6:0] ev, av;
            eff = REV ? (128 - tx_shift[rx_cnt]) % 128 : tx_shift[rx_cnt];
            bad = -1; ev = '0; av = '0;
            for (int i = 0; i < 128; i++) begin
              if (bad < 0 && out_lanes[i*7 +: 7] != lane_val(tx_seed[rx_cnt], (i + eff) % 256)) begin
                bad = i;
                av = out_lanes[i*7 +: 7];
                ev = lane_val(tx_seed[rx_cnt], (i + eff) % 256);
              end
            end
            if (bad >= 0) begin
              m_err++;
              $display("FAIL %s beat %0d shift %0d lane %0d actual %0d expected %0d",
                       REV ? "R2" : "R1", rx_cnt, tx_shift[rx_cnt], bad, av, ev);
            end
          end
          rx_cnt++;
        end
        prev_stall = out_valid && !out_ready;
        prev_lanes = out_lanes;
      end
    end
  end

  initial begin
    in_valid = 1'b0; in_shift = '0; in_lanes = '0; bp_en = 1'b0; done = 1'b0;
    tx_cnt = 0; d_chk = 0; d_err = 0;
    wait (rst_n === 1'b1);
    @(negedge clk);
    // R8 reset state
    dchk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    dchk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    // R4 / R5 latency of a single beat
    @(posedge clk);
    #1;
    send(5, 0);
    in_valid = 1'b0;
    @(negedge clk);
    dchk(out_valid == !REV, REV ? "R5 early" : "R4 first", int'(out_valid), int'(!REV));
    @(negedge clk);
    dchk(out_valid == REV, REV ? "R5 second" : "R4 drained", int'(out_valid), int'(REV));
    repeat (3) @(posedge clk);
    #1;
    // R3 / R10: every amount, back to back, amounts changing each beat
    for (int s = 0; s < 128; s++) send(s, s + 1);
    in_valid = 1'b0;
    // R6 / R9: scrambled amounts with random back-pressure and idle gaps
    bp_en = 1'b1;
    for (int k = 0; k < 128; k++) begin
      send((k * 37 + 11) % 128, 200 + k);
      if (k % 5 == 0) begin
        in_valid = 1'b0;
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    bp_en = 1'b0;
    for (int w = 0; w < 200 && rx_cnt < tx_cnt; w++) @(posedge clk);
    repeat (5) @(posedge clk);
    // R9 no beat lost or duplicated
    dchk(rx_cnt == tx_cnt, "R9 beat count", rx_cnt, tx_cnt);
    done = 1'b1;
  end
endmodule

module lane_rotator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   chk_f, err_f, chk_r, err_r, cyc;
  logic done_f, done_r;

  always #2 clk = ~clk;

  lane_rotator_tb_lane #(.REV(1'b0)) fwd_i (.clk(clk), .rst_n(rst_n), .n_chk(chk_f), .n_err(err_f), .done(done_f));
  lane_rotator_tb_lane #(.REV(1'b1)) rev_i (.clk(clk), .rst_n(rst_n), .n_chk(chk_r), .n_err(err_r), .done(done_r));

  initial begin
    int wd_err;
    wd_err = 0;
    cyc = 0;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    while (!(done_f === 1'b1 && done_r === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 100000) begin
      wd_err = 1;
      $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", chk_f + chk_r + wd_err, err_f + err_r + wd_err);
    $finish;
  end
endmodule